// File: doc/BRIEF.md
# Hierarchical Table-Based Packet Router

This block is a five-port packet switch for a tree-shaped on-chip network. Every node is addressed by a chip, cluster and rank tuple carried in the top bits of a packet's first word. Ports 0 to 3 face local processors. Port 4 is the uplink to the next level of the hierarchy. Each input and each output is a valid/ready stream with start and finish flags that mark packet boundaries.

A parameter fixes one of two forwarding modes for each instance:

- **Local mode:** a packet for the router's own cluster goes to the port named by its rank. Every other packet goes to the uplink.
- **Fabric mode:** rank is ignored. The chip and cluster fields are matched against an eight-entry prefix table. The table is a parameter, so its contents are fixed when the design is elaborated.

Each output has a round-robin arbiter. The arbiter grants the output to one input for a whole packet.

Back-pressure rules:

- A word moves only in a cycle where both valid and ready are high.
- A source must hold its word and flags stable while valid is high and ready is low.
- An input's ready is its owning output's ready, passed through combinationally.
- An input with no granted output sees ready low.

Top module: `hr_router`

## Requirements
- R1: A word moves from an input to an output only in a cycle with both valid and ready high. Data and flags reach the output unchanged. With the default 16-bit word, the address sits in bits [15:14] (chip), [13:12] (cluster) and [11:10] (rank). Only the word flagged first is decoded.
- R2: In local mode, a first word whose cluster equals the instance's own cluster goes to the output whose number equals its rank (0 to 3).
- R3: In local mode, a first word for any other cluster goes to output 4, whatever its rank.
- R4: In fabric mode, entry k sits at bits [12k+11:12k] of the table parameter. From the MSB, an entry holds: valid, chip value (2 bits), chip mask (2 bits), cluster value (2 bits), cluster mask (2 bits), port (3 bits).
  - An entry matches when valid is set and ((field XOR value) AND mask) is zero, for both chip and cluster.
  - The lowest-numbered matching entry wins.
  - Rank plays no part in the match.
  - When no entry matches, the packet goes to output 4.
- R5: The default table works as follows:
  - chip 0 with cluster 0 (the instance's own address, which is the host entry in slot 0) goes to port 0;
  - any other chip-0 cluster goes to port 1;
  - chip 1 goes to port 2;
  - chip 2 with clusters 2 or 3 goes to port 3;
  - everything else goes to port 4.
- R6: Once an output is granted to an input, it carries only that input's words until the word flagged last has moved.
- R7: Each output picks among requesting inputs in round-robin order. The search starts just after the input that held the output last.
- R8: A first word presented to an idle output appears at that output one cycle later. An output becomes idle in the cycle after its last word moves, and a new grant is made only while the output is idle.
- R9: While an output's ready is low, that output keeps valid and its word, and the owning input's ready is low.
- R10: During reset every output's valid and every input's ready are low, even when inputs present packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 5 | Per-input word valid |
| in_ready | output | 5 | Per-input word accepted |
| in_data | input | 5*W | Per-input word, input i in bits [i*W +: W] |
| in_first | input | 5 | Per-input start-of-packet flag |
| in_last | input | 5 | Per-input end-of-packet flag |
| out_valid | output | 5 | Per-output word valid |
| out_ready | input | 5 | Per-output sink ready |
| out_data | output | 5*W | Per-output word |
| out_first | output | 5 | Per-output start-of-packet flag |
| out_last | output | 5 | Per-output end-of-packet flag |

## Verification
A local-mode instance and a fabric-mode instance receive the same stimulus.

- **Address sweep:** a single-word packet with every one of the 64 address values is sent from each of the five inputs. This separates own-cluster from foreign-cluster routing in local mode. In fabric mode it separates each table entry, the priority of the host entry over its broader neighbour, and the miss default. It also fixes the one-cycle grant latency.
- **Contention:** two inputs send back-to-back multi-word packets to one output. The header order shows round-robin versus fixed priority, and word contiguity shows packet locking.
- **Alternating sink stall:** the same contention test is repeated with out_ready toggling every cycle. Any word lost or repeated while the sink stalls then shows up in the word counts.

// File: rtl/hr_pkg.sv
package hr_pkg;
  localparam int NPORT     = 5;
  localparam int PORT_W    = 3;
  localparam int FIELD_W   = 2;
  localparam int ADDR_W    = 3 * FIELD_W;
  localparam int TBL_DEPTH = 8;
  localparam int ENTRY_W   = 1 + 4 * FIELD_W + PORT_W;

  typedef logic [PORT_W-1:0] port_t;
  localparam port_t UPLINK = port_t'(4);

  typedef struct packed {
    logic               valid;
    logic [FIELD_W-1:0] chip_val;
    logic [FIELD_W-1:0] chip_msk;
    logic [FIELD_W-1:0] clu_val;
    logic [FIELD_W-1:0] clu_msk;
    port_t              port;
  } fwd_entry_t;

  // slot 3 .. slot 0; slots 4-7 unused
  localparam logic [TBL_DEPTH*ENTRY_W-1:0] DEFAULT_TABLE =
    {48'h0, 12'hDD3, 12'hB82, 12'h981, 12'h998};
endpackage

// File: rtl/hr_route_dec.sv
module hr_route_dec
  import hr_pkg::*;
#(
  parameter bit                              FABRIC     = 1'b0,
  parameter logic [FIELD_W-1:0]              MY_CLUSTER = '0,
  parameter logic [TBL_DEPTH*ENTRY_W-1:0]    FWD_TABLE  = DEFAULT_TABLE
) (
  input  logic [ADDR_W-1:0] addr,
  output port_t             dst
);
  logic [FIELD_W-1:0] chip, clu, rank;
  assign chip = addr[ADDR_W-1 -: FIELD_W];
  assign clu  = addr[ADDR_W-1-FIELD_W -: FIELD_W];
  assign rank = addr[FIELD_W-1:0];

  generate
    if (FABRIC) begin : g_fabric
      fwd_entry_t ent;
      logic unused_rank;
      assign unused_rank = ^rank;
      always_comb begin
        dst = UPLINK;
        ent = '0;
        // walk high to low so the lowest matching slot is applied last
        for (int k = TBL_DEPTH - 1; k >= 0; k--) begin
          ent = fwd_entry_t'(FWD_TABLE[k*ENTRY_W +: ENTRY_W]);
          if (ent.valid &&
              (((chip ^ ent.chip_val) & ent.chip_msk) == '0) &&
              (((clu  ^ ent.clu_val)  & ent.clu_msk)  == '0))
            dst = ent.port;
        end
      end
    end else begin : g_local
      logic unused_chip;
      assign unused_chip = ^chip;
      always_comb dst = (clu == MY_CLUSTER) ? port_t'(rank) : UPLINK;
    end
  endgenerate
endmodule

// File: rtl/hr_out_arb.sv
module hr_out_arb #(
  parameter int N     = 5,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  input  logic             fire_last,
  output logic             busy,
  output logic [IDX_W-1:0] owner
);
  logic             found;
  logic [IDX_W-1:0] pick;
  int               cand;

  always_comb begin
    found = 1'b0;
    pick  = owner;
    cand  = 0;
    for (int j = 1; j <= N; j++) begin
      cand = (int'(owner) + j) % N;
      if (!found && req[cand]) begin
        found = 1'b1;
        pick  = IDX_W'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      owner <= IDX_W'(N - 1);
    end else if (busy) begin
      if (fire_last) busy <= 1'b0;
    end else if (found) begin
      busy  <= 1'b1;
      owner <= pick;
    end
  end

  a_r6_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !fire_last |=> busy && $stable(owner));
  a_r8_free_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    busy && fire_last |=> !busy);
  a_r8_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && (req == '0) |=> !busy);
  a_r7_rotates: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && ($countones(req) > 1) |=> busy && (owner != $past(owner)));
endmodule

// File: rtl/hr_router.sv
module hr_router
  import hr_pkg::*;
#(
  parameter int                           W          = 16,
  parameter bit                           FABRIC     = 1'b0,
  parameter logic [FIELD_W-1:0]           MY_CLUSTER = '0,
  parameter logic [TBL_DEPTH*ENTRY_W-1:0] FWD_TABLE  = DEFAULT_TABLE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORT-1:0]     in_valid,
  output logic [NPORT-1:0]     in_ready,
  input  logic [NPORT*W-1:0]   in_data,
  input  logic [NPORT-1:0]     in_first,
  input  logic [NPORT-1:0]     in_last,
  output logic [NPORT-1:0]     out_valid,
  input  logic [NPORT-1:0]     out_ready,
  output logic [NPORT*W-1:0]   out_data,
  output logic [NPORT-1:0]     out_first,
  output logic [NPORT-1:0]     out_last
);
  localparam int N     = NPORT;
  localparam int IDX_W = $clog2(N);

  port_t            dst   [N];
  logic [N-1:0]     busy;
  logic [IDX_W-1:0] owner [N];
  logic [N-1:0]     owned [N];

  generate
    for (genvar i = 0; i < N; i++) begin : g_in
      hr_route_dec #(
        .FABRIC(FABRIC), .MY_CLUSTER(MY_CLUSTER), .FWD_TABLE(FWD_TABLE)
      ) u_dec (
        .addr(in_data[i*W+W-1 -: ADDR_W]),
        .dst (dst[i])
      );
    end

    for (genvar o = 0; o < N; o++) begin : g_out
      logic [N-1:0] req;
      logic         fire_last;
      always_comb
        for (int i = 0; i < N; i++)
          req[i] = in_valid[i] && in_first[i] && (dst[i] == port_t'(o));

      assign out_valid[o]        = busy[o] && in_valid[owner[o]];
      assign out_data[o*W +: W]  = in_data[owner[o]*W +: W];
      assign out_first[o]        = in_first[owner[o]];
      assign out_last[o]         = in_last[owner[o]];
      assign fire_last           = out_valid[o] && out_ready[o] && in_last[owner[o]];

      hr_out_arb #(.N(N)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(req), .fire_last(fire_last),
        .busy(busy[o]), .owner(owner[o])
      );
    end

    for (genvar i = 0; i < N; i++) begin : g_own
      always_comb
        for (int o = 0; o < N; o++)
          owned[i][o] = busy[o] && (owner[o] == IDX_W'(i));
      assign in_ready[i] = |(owned[i] & out_ready);

      a_r6_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(owned[i]));
    end
  endgenerate
endmodule

// File: tb/hr_router_tb_top.sv
module hr_router_tb_top;
  import hr_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int N = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [N-1:0]   iv = '0, ifst = '0, ilst = '0, ordy = '1;
  logic [N*W-1:0] idat = '0;
  logic [N-1:0]   rdy_l, ov_l, of_l, ol_l, rdy_f, ov_f, of_f, ol_f;
  logic [N*W-1:0] od_l, od_f;

  hr_router #(.W(W), .FABRIC(1'b0), .MY_CLUSTER(2'd1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(iv), .in_ready(rdy_l), .in_data(idat),
    .in_first(ifst), .in_last(ilst), .out_valid(ov_l), .out_ready(ordy),
    .out_data(od_l), .out_first(of_l), .out_last(ol_l));

  hr_router #(.W(W), .FABRIC(1'b1), .MY_CLUSTER(2'd0)) dut_f (
    .clk(clk), .rst_n(rst_n), .in_valid(iv), .in_ready(rdy_f), .in_data(idat),
    .in_first(ifst), .in_last(ilst), .out_valid(ov_f), .out_ready(ordy),
    .out_data(od_f), .out_first(of_f), .out_last(ol_f));

  int checks = 0, errors = 0;
  int npk[N], wi[N], plen[N];
  logic [5:0] addr[N];
  bit stall_mode = 1'b0;
  int cyc = 0;
  int ev_cnt[2], ev_port[2], ev_cyc[2], nord[2], words[2];
  logic [W-1:0] ev_word[2];
  int ord[2][16];
  int cur_src[2][N];
  int contig_err, stall_err, rdy_mismatch;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive();
    for (int i = 0; i < N; i++) begin
      iv[i]   = npk[i] > 0;
      ifst[i] = wi[i] == 0;
      ilst[i] = wi[i] == plen[i] - 1;
      idat[i*W +: W] = {addr[i], 3'b000, 3'(i), 4'(wi[i])};
    end
    ordy = (stall_mode && cyc[0]) ? '0 : '1;
  endtask

  task automatic clear_all();
    for (int d = 0; d < 2; d++) begin
      ev_cnt[d] = 0; ev_port[d] = -1; ev_cyc[d] = -1; nord[d] = 0; words[d] = 0;
      ev_word[d] = '0;
      for (int o = 0; o < N; o++) cur_src[d][o] = -1;
    end
    contig_err = 0; stall_err = 0; rdy_mismatch = 0;
    for (int i = 0; i < N; i++) begin npk[i] = 0; wi[i] = 0; plen[i] = 1; addr[i] = '0; end
  endtask

  task automatic observe(int d, logic [N-1:0] v, logic [N-1:0] f,
                         logic [N*W-1:0] dat, logic [N-1:0] rdy);
    for (int o = 0; o < N; o++) begin
      logic [W-1:0] wd;
      int s;
      wd = dat[o*W +: W];
      s  = int'(wd[6:4]);
      if (v[o]) begin
        if (ordy[o]) begin
          words[d]++;
          if (f[o]) begin
            ev_cnt[d]++; ev_port[d] = o; ev_cyc[d] = cyc; ev_word[d] = wd;
            if (nord[d] < 16) ord[d][nord[d]] = s;
            nord[d]++;
            cur_src[d][o] = s;
          end else if (s != cur_src[d][o]) contig_err++;
        end else if (s < N && rdy[s]) stall_err++;
      end
    end
  endtask

  task automatic run(int ncyc);
    for (int c = 0; c < ncyc; c++) begin
      logic [N-1:0] rl;
      cyc = c;
      @(negedge clk);
      observe(0, ov_l, of_l, od_l, rdy_l);
      observe(1, ov_f, of_f, od_f, rdy_f);
      if (rdy_l != rdy_f) rdy_mismatch++;
      rl = rdy_l & rdy_f;
      @(posedge clk); #1;
      for (int i = 0; i < N; i++)
        if (iv[i] && rl[i]) begin
          wi[i]++;
          if (wi[i] == plen[i]) begin wi[i] = 0; npk[i]--; end
        end
      cyc = c + 1;
      drive();
    end
  endtask

  function automatic int exp_local(logic [5:0] a);
    return (a[3:2] == 2'd1) ? int'(a[1:0]) : 4;
  endfunction

  function automatic int exp_fabric(logic [5:0] a);
    int chip = int'(a[5:4]);
    int clu  = int'(a[3:2]);
    if (chip == 0 && clu == 0) return 0;
    if (chip == 0) return 1;
    if (chip == 1) return 2;
    if (chip == 2 && clu >= 2) return 3;
    return 4;
  endfunction

  task automatic contend(int a, int b, int np, bit stall, int ncyc, int first_src);
    clear_all();
    stall_mode = stall;
    npk[a] = np; npk[b] = np; plen[a] = 3; plen[b] = 3;
    addr[a] = 6'b000100; addr[b] = 6'b000100;
    cyc = 0; drive();
    run(ncyc);
    for (int d = 0; d < 2; d++) begin
      check(nord[d] == 2*np, "R7", "packet count", nord[d], 2*np);
      for (int k = 0; k < 2*np && k < 16; k++) begin
        int e = (k % 2 == 0) ? first_src : (first_src == a ? b : a);
        check(ord[d][k] == e, "R7", "round-robin header source", ord[d][k], e);
      end
      check(words[d] == 6*np, "R9", "words delivered", words[d], 6*np);
    end
    check(contig_err == 0, "R6", "interleaved words", contig_err, 0);
    check(stall_err == 0, "R9", "input ready during output stall", stall_err, 0);
    check(rdy_mismatch == 0, "R1", "ready agreement", rdy_mismatch, 0);
    stall_mode = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_all();
    iv = 5'b00001; ifst = 5'b00001; ilst = 5'b00001;
    idat[W-1:0] = 16'h1000;
    repeat (3) @(negedge clk);
    check(ov_l == '0 && ov_f == '0, "R10", "out_valid in reset", int'(ov_l | ov_f), 0);
    check(rdy_l == '0 && rdy_f == '0, "R10", "in_ready in reset", int'(rdy_l | rdy_f), 0);
    iv = '0;
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R2 R3 R4 R5 R8 R1: single-word packets, all addresses from all inputs
    for (int s = 0; s < N; s++) begin
      for (int a = 0; a < 64; a++) begin
        logic [W-1:0] ew;
        int el, ef;
        clear_all();
        npk[s] = 1; addr[s] = 6'(a);
        cyc = 0; drive();
        run(4);
        el = exp_local(6'(a));
        ef = exp_fabric(6'(a));
        ew = {6'(a), 3'b000, 3'(s), 4'd0};
        check(ev_cnt[0] == 1 && ev_port[0] == el,
              (a[3:2] == 1) ? "R2" : "R3", "local output port", ev_port[0], el);
        check(ev_cnt[1] == 1 && ev_port[1] == ef,
              (ef == 0) ? "R5" : "R4", "fabric output port", ev_port[1], ef);
        check(ev_cyc[0] == 1 && ev_cyc[1] == 1, "R8", "header latency",
              ev_cyc[0], 1);
        check(ev_word[0] == ew && ev_word[1] == ew, "R1", "word passthrough",
              int'(ev_word[0]), int'(ew));
      end
    end

    // R6 R7: inputs 1 and 3 contend; last owner after the sweep is input 4
    contend(1, 3, 3, 1'b0, 30, 1);
    // R9 R7: stalled sink, inputs 0 and 4; last owner is now input 3
    contend(0, 4, 2, 1'b1, 50, 4);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule